// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the software-visible control store of a PCI host bridge. It answers a simple synchronous bus that carries an address, a write strobe with write data, and a read strobe with registered read data. The low 16 address bits select a word inside a 64 KiB window. The window holds IOMMU control words, a bank of interrupt mapping registers, PCI control words and a reset control/status register. Offsets that decode to nothing read as zero, and writes to them are dropped.

The interrupt mapping registers carry a fixed routing value in their low bits. Only their top bit, the enable, can be written. The enables are exported as a vector so that the interrupt routing logic can gate each mapped source. The reset register combines write-one-to-clear status bits with directly written request bits. A write that sets a request bit produces a one-cycle request pulse, either for a soft power-on reset or for a soft externally-initiated reset.

A separate device reset input marks each system reset. On every device reset the block clears all interrupt enables. It also keeps a saturating count of device resets, so that only the first device reset after power-up, or after a soft power-on request, records a power-on status in the reset register.

Top module: `hbr_csr`

## Requirements
- R1: After power-up reset, mapping register i reads 0x7C0 | (i << 2). The IOMMU words, the PCI control words and the reset register read zero. `map_enable` and both request pulses are low.
- R2: Three IOMMU words sit at 0x200, 0x204 and 0x208 and are fully readable and writable. Offsets 0x20C to 0x3FF read zero and ignore writes.
- R3: Mapping register i is live at 0xC04 + 8*i. A write changes only bit 31 and leaves bits 30:0 unchanged. The word at 0xC00 + 8*i reads zero and ignores writes.
- R4: `map_enable[i]` always equals bit 31 of mapping register i. It changes only on a write to that register or on a device reset.
- R5: Twelve PCI control words at 0x2000 + 4*k (k = 0 to 11) are fully readable and writable.
- R6: The reset register lives at 0xF024, with bits 26:0 reading zero and the word at 0xF020 reading zero. Write data is masked to bits 31:27. A 1 written to bit 31, 28 or 27 clears that bit, and a 0 leaves it unchanged. Bits 30 and 29 take the written value.
- R7: A write to 0xF024 with bit 30 set makes `soft_pwr_req` high for exactly the one cycle after the write cycle and clears the reset counter. If bit 30 is clear and bit 29 is set, `soft_ext_req` pulses in the same way instead. The two pulses are never high together.
- R8: A device reset clears bit 31 of every mapping register. If the reset counter is zero, the reset register becomes 0x8000_0000. The counter then increments and saturates at its maximum, so it never wraps back to the first-reset state.
- R9: In a cycle in which `dev_rst` is high, a bus write is dropped and produces no request pulse.
- R10: Reads of undecoded offsets return zero, and writes to them change no readable state.
- R11: `rd_data` takes the addressed word in the cycle after `rd_en` is high and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| dev_rst | input | 1 | Synchronous one-cycle device reset event |
| addr | input | 16 | Byte offset inside the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| map_enable | output | 8 | Enable bit of each interrupt mapping register |
| soft_pwr_req | output | 1 | One-cycle soft power-on reset request |
| soft_ext_req | output | 1 | One-cycle soft externally-initiated reset request |

## Verification
The bench builds the block with its default bank sizes (three IOMMU words, eight mapping registers, twelve PCI control words) and overrides the reset counter width to one bit. With a one-bit counter, saturation is reached after the first device reset. A wrapping counter would then return to zero on the second device reset, so the bench clears the power-on status and issues a third device reset: a wrapping design would reload the status, and the saturating design must not. The default bank sizes put every live word, the hole after the IOMMU words and the first offset past the PCI control words within reach of directed accesses.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_IOMMU,
      RG_HOLE,
      RG_MAP,
      RG_PCICTL,
      RG_RSTCTL
   } region_e;

   localparam int IDX_W = 4;

   // reset register: only bits 31:27 exist; positions inside the 5-bit field
   localparam int RC_LSB    = 27;
   localparam int RC_W      = 5;
   localparam logic [RC_W-1:0] RC_W1C   = 5'b10011;  // bits 31, 28, 27
   localparam logic [RC_W-1:0] RC_WRITE = 5'b01100;  // bits 30, 29
   localparam int RC_F_PWRON = 4;                    // bit 31
   localparam int RC_F_SWPWR = 3;                    // bit 30
   localparam int RC_F_SWEXT = 2;                    // bit 29

endpackage

// File: rtl/hbr_addr_dec.sv
module hbr_addr_dec
   import hbr_pkg::*;
#(
   parameter int N_IOMMU  = 3,
   parameter int N_MAP    = 8,
   parameter int N_PCICTL = 12
) (
   input  logic [15:0]      addr,
   output region_e          region,
   output logic             live,
   output logic [IDX_W-1:0] idx
);

   localparam logic [15:0] IOMMU_LO = 16'h0200;
   localparam logic [15:0] IOMMU_HI = 16'(32'h0200 + 4 * N_IOMMU - 1);
   localparam logic [15:0] HOLE_HI  = 16'h03FF;
   localparam logic [15:0] MAP_LO   = 16'h0C00;
   localparam logic [15:0] MAP_HI   = 16'(32'h0C00 + 8 * N_MAP - 1);
   localparam logic [15:0] PCI_LO   = 16'h2000;
   localparam logic [15:0] PCI_HI   = 16'(32'h2000 + 4 * N_PCICTL - 1);
   localparam logic [15:0] RC_LO    = 16'hF020;
   localparam logic [15:0] RC_HI    = 16'hF027;

   always_comb begin
      region = RG_NONE;
      live   = 1'b0;
      idx    = '0;
      if (addr >= IOMMU_LO && addr <= IOMMU_HI) begin
         region = RG_IOMMU;
         live   = 1'b1;
         idx    = {2'b00, addr[3:2]};
      end else if (addr >= IOMMU_LO && addr <= HOLE_HI) begin
         region = RG_HOLE;
      end else if (addr >= MAP_LO && addr <= MAP_HI) begin
         region = RG_MAP;
         live   = addr[2];
         idx    = {1'b0, addr[5:3]};
      end else if (addr >= PCI_LO && addr <= PCI_HI) begin
         region = RG_PCICTL;
         live   = 1'b1;
         idx    = addr[5:2];
      end else if (addr >= RC_LO && addr <= RC_HI) begin
         region = RG_RSTCTL;
         live   = addr[2];
      end
   end

endmodule

// File: rtl/hbr_map_bank.sv
module hbr_map_bank
   import hbr_pkg::*;
#(
   parameter int N_MAP = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dev_rst,
   input  logic                   wr_stb,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic                   wr_en_bit,
   output logic [N_MAP-1:0]       en_q,
   output logic [N_MAP-1:0][31:0] word_q
);

   for (genvar i = 0; i < N_MAP; i++) begin : g_map
      localparam logic [30:0] ROUTE = 31'((32'h1F << 6) | (i << 2));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[i] <= 1'b0;
         else if (dev_rst)
            en_q[i] <= 1'b0;
         else if (wr_stb && wr_idx == IDX_W'(i))
            en_q[i] <= wr_en_bit;
      end

      assign word_q[i] = {en_q[i], ROUTE};
   end

endmodule

// File: rtl/hbr_rst_ctl.sv
module hbr_rst_ctl
   import hbr_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dev_rst,
   input  logic            wr_stb,
   input  logic [RC_W-1:0] wr_field,
   output logic [31:0]     rc_word,
   output logic            swpwr_pulse,
   output logic            swext_pulse
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [RC_W-1:0]  st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [RC_W-1:0]  st_wr;

   assign st_wr   = (st_q & ~(wr_field & RC_W1C) & ~RC_WRITE) | (wr_field & RC_WRITE);
   assign rc_word = {st_q, {RC_LSB{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= '0;
         cnt_q       <= '0;
         swpwr_pulse <= 1'b0;
         swext_pulse <= 1'b0;
      end else begin
         swpwr_pulse <= 1'b0;
         swext_pulse <= 1'b0;
         if (dev_rst) begin
            if (cnt_q == '0)
               st_q <= RC_W'(1) << RC_F_PWRON;
            if (cnt_q != CNT_MAX)
               cnt_q <= cnt_q + 1'b1;
         end else if (wr_stb) begin
            st_q        <= st_wr;
            swpwr_pulse <= wr_field[RC_F_SWPWR];
            swext_pulse <= !wr_field[RC_F_SWPWR] && wr_field[RC_F_SWEXT];
            if (wr_field[RC_F_SWPWR])
               cnt_q <= '0;
         end
      end
   end

endmodule

// File: rtl/hbr_csr.sv
module hbr_csr
   import hbr_pkg::*;
#(
   parameter int N_IOMMU   = 3,
   parameter int N_MAP     = 8,
   parameter int N_PCICTL  = 12,
   parameter int RST_CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dev_rst,
   input  logic [15:0]      addr,
   input  logic             wr_en,
   input  logic [31:0]      wr_data,
   input  logic             rd_en,
   output logic [31:0]      rd_data,
   output logic [N_MAP-1:0] map_enable,
   output logic             soft_pwr_req,
   output logic             soft_ext_req
);

   if (N_IOMMU < 1 || N_IOMMU > 4) begin : g_bad_iommu
      $error("hbr_csr: N_IOMMU must be 1..4");
   end
   if (N_MAP < 1 || N_MAP > 8) begin : g_bad_map
      $error("hbr_csr: N_MAP must be 1..8");
   end
   if (N_PCICTL < 1 || N_PCICTL > 16) begin : g_bad_pci
      $error("hbr_csr: N_PCICTL must be 1..16");
   end
   if (RST_CNT_W < 1) begin : g_bad_cnt
      $error("hbr_csr: RST_CNT_W must be at least 1");
   end

   region_e          region;
   logic             live;
   logic [IDX_W-1:0] idx;
   logic             wr_ok;

   logic [N_IOMMU-1:0][31:0]  iommu_q;
   logic [N_PCICTL-1:0][31:0] pci_q;
   logic [N_MAP-1:0][31:0]    map_word;
   logic [31:0]               rc_word;
   logic [31:0]               rd_mux;

   hbr_addr_dec #(
      .N_IOMMU (N_IOMMU),
      .N_MAP   (N_MAP),
      .N_PCICTL(N_PCICTL)
   ) u_dec (
      .addr  (addr),
      .region(region),
      .live  (live),
      .idx   (idx)
   );

   assign wr_ok = wr_en && !dev_rst && live;

   for (genvar k = 0; k < N_IOMMU; k++) begin : g_iommu
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            iommu_q[k] <= '0;
         else if (wr_ok && region == RG_IOMMU && idx == IDX_W'(k))
            iommu_q[k] <= wr_data;
      end
   end

   for (genvar k = 0; k < N_PCICTL; k++) begin : g_pci
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pci_q[k] <= '0;
         else if (wr_ok && region == RG_PCICTL && idx == IDX_W'(k))
            pci_q[k] <= wr_data;
      end
   end

   hbr_map_bank #(
      .N_MAP(N_MAP)
   ) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_rst  (dev_rst),
      .wr_stb   (wr_ok && region == RG_MAP),
      .wr_idx   (idx),
      .wr_en_bit(wr_data[31]),
      .en_q     (map_enable),
      .word_q   (map_word)
   );

   hbr_rst_ctl #(
      .CNT_W(RST_CNT_W)
   ) u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .dev_rst    (dev_rst),
      .wr_stb     (wr_ok && region == RG_RSTCTL),
      .wr_field   (wr_data[31:RC_LSB]),
      .rc_word    (rc_word),
      .swpwr_pulse(soft_pwr_req),
      .swext_pulse(soft_ext_req)
   );

   always_comb begin
      rd_mux = '0;
      if (live) begin
         unique case (region)
            RG_IOMMU:
               for (int k = 0; k < N_IOMMU; k++)
                  if (idx == IDX_W'(k)) rd_mux = iommu_q[k];
            RG_MAP:
               for (int k = 0; k < N_MAP; k++)
                  if (idx == IDX_W'(k)) rd_mux = map_word[k];
            RG_PCICTL:
               for (int k = 0; k < N_PCICTL; k++)
                  if (idx == IDX_W'(k)) rd_mux = pci_q[k];
            RG_RSTCTL:
               rd_mux = rc_word;
            default:
               rd_mux = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_mux;
   end

endmodule

// File: rtl/hbr_csr_chk.sv
module hbr_csr_chk #(
   parameter int N_MAP = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dev_rst,
   input logic [15:2]      addr_w,
   input logic             wr_en,
   input logic             wr_b30,
   input logic             rd_en,
   input logic [31:0]      rd_data,
   input logic [N_MAP-1:0] map_enable,
   input logic             soft_pwr_req,
   input logic             soft_ext_req
);

   localparam logic [15:2] RC_WORD = 14'h3C09;   // 0xF024

   // R7: power-on request lasts exactly one cycle
   a_r7_pwr_single: assert property (@(posedge clk) disable iff (!rst_n)
      soft_pwr_req |=> !soft_pwr_req);

   // R7: external request lasts exactly one cycle
   a_r7_ext_single: assert property (@(posedge clk) disable iff (!rst_n)
      soft_ext_req |=> !soft_ext_req);

   // R7: the two requests never coincide
   a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(soft_pwr_req && soft_ext_req));

   // R7 and R9: a power-on request follows an accepted write of bit 30
   a_r9_pwr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      soft_pwr_req |-> $past(wr_en && !dev_rst && addr_w == RC_WORD && wr_b30));

   // R8: device reset drops every enable
   a_r8_dev_clears: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> map_enable == '0);

   // R4: enables move only on a write or a device reset
   a_r4_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !dev_rst) |=> $stable(map_enable));

   // R11: read data holds without a read strobe
   a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

bind hbr_csr hbr_csr_chk #(.N_MAP(N_MAP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dev_rst     (dev_rst),
   .addr_w      (addr[15:2]),
   .wr_en       (wr_en),
   .wr_b30      (wr_data[30]),
   .rd_en       (rd_en),
   .rd_data     (rd_data),
   .map_enable  (map_enable),
   .soft_pwr_req(soft_pwr_req),
   .soft_ext_req(soft_ext_req)
);

// File: tb/hbr_csr_tb_top.sv
`timescale 1ns/1ps
module hbr_csr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_rst = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [7:0]  map_enable;
   logic        soft_pwr_req;
   logic        soft_ext_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   hbr_csr #(.RST_CNT_W(1)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_rst     (dev_rst),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_en       (rd_en),
      .rd_data     (rd_data),
      .map_enable  (map_enable),
      .soft_pwr_req(soft_pwr_req),
      .soft_ext_req(soft_ext_req)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // driver
   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic with_rst = 1'b0);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1; dev_rst = with_rst;
      @(negedge clk);
      wr_en = 1'b0; dev_rst = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_dev_rst();
      @(negedge clk);
      dev_rst = 1'b1;
      @(negedge clk);
      dev_rst = 1'b0;
   endtask

   // monitor
   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            chk(rd_data, 32'hx, "scoreboard underflow");
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rd_data, e, t);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd0, "R1 pulses idle");
      chk({24'd0, map_enable}, 32'd0, "R1 enables low");
      for (int i = 0; i < 8; i++)
         rd(16'(16'hC04 + 8 * i), 32'h7C0 | (i << 2), "R1 map default");
      rd(16'hF024, 32'h0, "R1 reset reg zero");
      rd(16'h0200, 32'h0, "R1 iommu zero");
      rd(16'h2000, 32'h0, "R1 pci zero");

      // R8 first device reset records power-on
      pulse_dev_rst();
      rd(16'hF024, 32'h8000_0000, "R8 first reset status");

      // R3 / R4 mapping registers
      wr(16'hC1C, 32'hFFFF_FFFF);
      rd(16'hC1C, 32'h8000_07CC, "R3 only bit31 written");
      chk({24'd0, map_enable}, 32'h08, "R4 enable of map 3");
      wr(16'hC2C, 32'h7FFF_FFFF);
      rd(16'hC2C, 32'h0000_07D4, "R3 low bits kept map 5");
      wr(16'hC18, 32'h0000_0000);
      rd(16'hC18, 32'h0, "R3 even word reads zero");
      rd(16'hC1C, 32'h8000_07CC, "R3 even word write ignored");
      wr(16'hC3C, 32'h8000_0000);
      chk({24'd0, map_enable}, 32'h88, "R4 enables 3 and 7");

      // R8 later resets: enables cleared, counter saturates
      pulse_dev_rst();
      chk({24'd0, map_enable}, 32'h00, "R8 enables cleared");
      rd(16'hF024, 32'h8000_0000, "R8 status kept on second reset");
      wr(16'hF024, 32'h8000_0000);
      rd(16'hF024, 32'h0, "R6 bit31 write-one-clear");
      pulse_dev_rst();
      rd(16'hF024, 32'h0, "R8 saturated counter no reload");

      // R2 IOMMU words and hole
      wr(16'h0200, 32'h1122_3344);
      wr(16'h0204, 32'hDEAD_BEEF);
      wr(16'h0208, 32'h0BAD_F00D);
      wr(16'h020C, 32'hFFFF_FFFF);
      wr(16'h03FC, 32'hFFFF_FFFF);
      rd(16'h0200, 32'h1122_3344, "R2 iommu word 0");
      rd(16'h0208, 32'h0BAD_F00D, "R2 iommu word 2");
      rd(16'h020C, 32'h0, "R2 hole start reads zero");
      rd(16'h03FC, 32'h0, "R2 hole end reads zero");
      rd(16'h0204, 32'hDEAD_BEEF, "R2 iommu word 1");

      // R11 hold
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(rd_data, 32'hDEAD_BEEF, "R11 read data held");

      // R5 PCI control
      for (int k = 0; k < 12; k++)
         wr(16'(16'h2000 + 4 * k), 32'hC0DE_0000 | (k * 32'h111));
      for (int k = 0; k < 12; k++)
         rd(16'(16'h2000 + 4 * k), 32'hC0DE_0000 | (k * 32'h111), "R5 pci word");
      rd(16'h2030, 32'h0, "R10 past pci bank");

      // R6 / R7 external request
      wr(16'hF024, 32'h27FF_FFFF);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd1, "R7 ext pulse");
      @(negedge clk);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd0, "R7 ext pulse one cycle");
      rd(16'hF024, 32'h2000_0000, "R6 masked write bit29");
      wr(16'hF020, 32'hFFFF_FFFF);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd0, "R6 F020 no pulse");
      rd(16'hF020, 32'h0, "R6 F020 reads zero");
      rd(16'hF024, 32'h2000_0000, "R6 F020 write ignored");

      // R7 power-on request takes priority and rearms the counter
      wr(16'hF024, 32'h6000_0000);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd2, "R7 pwr pulse only");
      @(negedge clk);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd0, "R7 pwr pulse one cycle");
      rd(16'hF024, 32'h6000_0000, "R6 bits 30 29 written");
      pulse_dev_rst();
      rd(16'hF024, 32'h8000_0000, "R8 reload after soft power-on");
      wr(16'hF024, 32'h1800_0000);
      rd(16'hF024, 32'h8000_0000, "R6 clear of zero bits and bits30 29 cleared");

      // R9 device reset beats a concurrent write
      wr(16'hC04, 32'h8000_0000, 1'b1);
      chk({24'd0, map_enable}, 32'h00, "R9 map write dropped");
      wr(16'hF024, 32'h4000_0000, 1'b1);
      chk({30'd0, soft_pwr_req, soft_ext_req}, 32'd0, "R9 no pulse");
      rd(16'hF024, 32'h8000_0000, "R9 reset reg unchanged");

      // R10 undecoded
      wr(16'h8000, 32'hFFFF_FFFF);
      rd(16'h8000, 32'h0, "R10 undecoded reads zero");
      rd(16'h0034, 32'h0, "R10 low hole reads zero");
      chk({24'd0, map_enable}, 32'h00, "R10 enables untouched");

      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule